// File: doc/BRIEF.md
# Adaptive Dictionary Bus Codec

This block lowers the toggle activity of a wide parallel bus by replacing frequently repeated high-order bit patterns with short dictionary references. Every word is cut into three fields. The lowest field is always sent unchanged. The middle field selects a slot in a small direct-mapped table. The top field, the key, is the part that the table remembers. The transmit side compares the key of each incoming word with the slot that the word's own middle field selects. On a match, only the low and middle lines carry new values, and a single status line is raised. On a mismatch, the whole word is driven and the slot is overwritten with the new key.

The receive side keeps a second table. It updates that table on exactly the same events, so the two tables never diverge and no handshake is needed between them. When the status line is high, the receiver restores the key from its own table. When the status line is low, it takes the key from the bus lines and stores it.

The top module wires the transmitter and receiver back to back and brings out the encoded bus so that the link between them can be observed. Each side uses one register stage, so a word appears on the bus one cycle after it is accepted and at the output one cycle after that.

Top module: `dict_bus_codec`

## Requirements
- R1: While reset is asserted and after it is released, bus_valid and out_valid are 0, and bus_word and out_word are all zeros, until the first valid input.
- R2: The word is split as follows: bypass field in_word[WO-1:0], slot index in_word[WO+WI-1:WO], key in_word[NW-1:WO+WI]. Both tables hold 2^WI keys and reset to zero, so a valid word with a zero key produces bus_hit = 1 right after reset.
- R3: A valid word whose key differs from the selected slot gives, on the next cycle, bus_valid = 1, bus_hit = 0, and bus_word equal to the input word.
- R4: A valid word whose key equals the selected slot gives, on the next cycle, bus_valid = 1 and bus_hit = 1. The lower WO+WI bits of bus_word equal those of the input. The key lines of bus_word keep the value they had in the previous cycle.
- R5: A miss writes the word's key into the slot addressed by its own index, on both sides. A later word with the same key and index then hits, and a later word with a different key at that index misses and replaces the slot.
- R6: Every valid input word reappears unchanged on out_word, with out_valid = 1, two cycles after it was presented. out_valid is 0 in every other cycle.
- R7: A cycle with in_valid = 0 leaves bus_word unchanged and bus_valid = 0, and it changes neither table.
- R8: When two consecutive valid words use the same index and the first one misses, the second is judged against the key written by the first. The receiver restores it correctly in the same cycle that it is writing the first key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word qualifier |
| in_word | input | NW | Word to transmit |
| bus_valid | output | 1 | Encoded transfer present on the link |
| bus_hit | output | 1 | Link status line: 1 = key taken from table, 0 = full word |
| bus_word | output | NW | Encoded link lines |
| out_valid | output | 1 | Rebuilt word qualifier |
| out_word | output | NW | Rebuilt word |

## Verification
Two things collide when consecutive words share an index. A miss writes a slot while the next word looks up that same slot, and at the receiver a table write for one word meets a table read for the following word. The bench provokes this with directed back-to-back pairs that share an index and alternate keys. It also runs long random streams and streams drawn from a few keys, where such collisions are frequent. It judges the results against a behavioural model of the table, which gives the expected bus_hit, bus_word and out_word for every clock.

// File: rtl/codec_pkg.sv
package codec_pkg;
   // Meaning of the link status line
   typedef enum logic {
      XFER_FULL = 1'b0,
      XFER_REF  = 1'b1
   } xfer_kind_e;
endpackage

// File: rtl/codec_dict_store.sv
module codec_dict_store #(
   parameter int KW = 24,
   parameter int IW = 4,
   localparam int DEPTH = 1 << IW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [IW-1:0] rd_idx,
   output logic [KW-1:0] rd_key,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [KW-1:0] wr_key
);
   logic [KW-1:0] slot [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int e = 0; e < DEPTH; e++) slot[e] <= '0;
      end else if (wr_en) begin
         slot[wr_idx] <= wr_key;
      end
   end

   assign rd_key = slot[rd_idx];

   // R5: a write is visible at its slot on the following cycle
   p_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> slot[$past(wr_idx)] == $past(wr_key));
endmodule

// File: rtl/codec_tx.sv
module codec_tx
   import codec_pkg::*;
#(
   parameter int NW = 32,
   parameter int WO = 4,
   parameter int WI = 4,
   localparam int LOW = WO + WI,
   localparam int KW  = NW - LOW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [NW-1:0] in_word,
   output logic          bus_valid,
   output logic          bus_hit,
   output logic [NW-1:0] bus_word
);
   logic [KW-1:0] key_in, key_tab;
   logic [WI-1:0] idx_in;
   logic          match;

   assign key_in = in_word[NW-1:LOW];
   assign idx_in = in_word[LOW-1:WO];
   assign match  = (key_tab == key_in);

   codec_dict_store #(.KW(KW), .IW(WI)) tab_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (idx_in),
      .rd_key (key_tab),
      .wr_en  (in_valid && !match),
      .wr_idx (idx_in),
      .wr_key (key_in)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_valid <= 1'b0;
         bus_hit   <= XFER_FULL;
         bus_word  <= '0;
      end else if (in_valid) begin
         bus_valid          <= 1'b1;
         bus_hit            <= match ? XFER_REF : XFER_FULL;
         bus_word[LOW-1:0]  <= in_word[LOW-1:0];
         if (!match) bus_word[NW-1:LOW] <= key_in;
      end else begin
         bus_valid <= 1'b0;
      end
   end

   // R4: on a reference transfer the key lines do not toggle
   p_key_lines_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_hit) |-> bus_word[NW-1:LOW] == $past(bus_word[NW-1:LOW]));
   // R4: low lines follow the accepted word
   p_low_lines_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> bus_word[LOW-1:0] == $past(in_word[LOW-1:0]));
   // R3: a full transfer carries the word unchanged
   p_full_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !match) |=> (bus_word == $past(in_word) && !bus_hit));
   // R7: idle cycles leave the link lines still
   p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(bus_word) && !bus_valid));
endmodule

// File: rtl/codec_rx.sv
module codec_rx
   import codec_pkg::*;
#(
   parameter int NW = 32,
   parameter int WO = 4,
   parameter int WI = 4,
   localparam int LOW = WO + WI,
   localparam int KW  = NW - LOW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_valid,
   input  logic          bus_hit,
   input  logic [NW-1:0] bus_word,
   output logic          out_valid,
   output logic [NW-1:0] out_word
);
   logic [KW-1:0] key_tab, key_sel;
   logic [WI-1:0] idx_bus;
   logic          is_ref;

   assign idx_bus = bus_word[LOW-1:WO];
   assign is_ref  = (bus_hit == XFER_REF);
   assign key_sel = is_ref ? key_tab : bus_word[NW-1:LOW];

   codec_dict_store #(.KW(KW), .IW(WI)) tab_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (idx_bus),
      .rd_key (key_tab),
      .wr_en  (bus_valid && !is_ref),
      .wr_idx (idx_bus),
      .wr_key (bus_word[NW-1:LOW])
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_word  <= '0;
      end else begin
         out_valid <= bus_valid;
         if (bus_valid) out_word <= {key_sel, bus_word[LOW-1:0]};
      end
   end

   // R6: one output per link transfer, one cycle later
   p_out_tracks_link_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(bus_valid));
endmodule

// File: rtl/dict_bus_codec.sv
module dict_bus_codec #(
   parameter int NW = 32,
   parameter int WO = 4,
   parameter int WI = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [NW-1:0] in_word,
   output logic          bus_valid,
   output logic          bus_hit,
   output logic [NW-1:0] bus_word,
   output logic          out_valid,
   output logic [NW-1:0] out_word
);
   generate
      if (WI < 1) begin : g_bad_wi
         $error("dict_bus_codec: WI must be at least 1");
      end
      if (WO < 0) begin : g_bad_wo
         $error("dict_bus_codec: WO must not be negative");
      end
      if (NW <= WO + WI) begin : g_bad_nw
         $error("dict_bus_codec: NW must leave a key field above WO+WI");
      end
      if (WI > 12) begin : g_big_tab
         $error("dict_bus_codec: WI above 12 makes an oversized table");
      end
   endgenerate

   codec_tx #(.NW(NW), .WO(WO), .WI(WI)) tx_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_word   (in_word),
      .bus_valid (bus_valid),
      .bus_hit   (bus_hit),
      .bus_word  (bus_word)
   );

   codec_rx #(.NW(NW), .WO(WO), .WI(WI)) rx_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_valid (bus_valid),
      .bus_hit   (bus_hit),
      .bus_word  (bus_word),
      .out_valid (out_valid),
      .out_word  (out_word)
   );

   // R6 and R8: the pair rebuilds every word two cycles later
   p_round_trip_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_word == $past(in_word, 2) && $past(in_valid, 2)));
   // R1: nothing leaves the pair without a prior input
   p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(in_valid) |-> !bus_valid);
endmodule

// File: tb/dict_bus_codec_tb.sv
module dict_bus_codec_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NW = 32;
   localparam int WO = 4;
   localparam int WI = 4;
   localparam int LOW = WO + WI;
   localparam int KW = NW - LOW;
   localparam int DEPTH = 1 << WI;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [NW-1:0] in_word = '0;
   logic          bus_valid, bus_hit, out_valid;
   logic [NW-1:0] bus_word, out_word;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // behavioural model state
   logic [KW-1:0] mdict [DEPTH];
   logic [KW-1:0] m_key_lines = '0;
   logic          eb_valid = 1'b0, eb_hit = 1'b0;
   logic [NW-1:0] eb_word = '0;
   logic          eo_valid = 1'b0;
   logic [NW-1:0] eo_word = '0;
   logic          p_valid = 1'b0;
   logic [NW-1:0] p_word = '0;
   string         ctx = "R6";

   always #(CLK_PERIOD/2) clk = ~clk;

   dict_bus_codec #(.NW(NW), .WO(WO), .WI(WI)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
      .bus_valid(bus_valid), .bus_hit(bus_hit), .bus_word(bus_word),
      .out_valid(out_valid), .out_word(out_word)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [NW-1:0] act, input logic [NW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // One clock: check what the previous inputs should have produced, then drive.
   task automatic step(input bit v, input logic [NW-1:0] w);
      logic [KW-1:0] k;
      logic [WI-1:0] ix;
      @(negedge clk);
      chk(bus_valid == eb_valid, eb_valid ? "R3/R4" : "R7", "bus_valid", NW'(bus_valid), NW'(eb_valid));
      if (eb_valid) begin
         chk(bus_hit == eb_hit, {eb_hit ? "R2/R4/R5 " : "R3/R5 ", ctx}, "bus_hit", NW'(bus_hit), NW'(eb_hit));
      end
      chk(bus_word == eb_word, eb_valid ? (eb_hit ? "R4" : "R3") : "R7", "bus_word", bus_word, eb_word);
      chk(out_valid == eo_valid, "R6", "out_valid", NW'(out_valid), NW'(eo_valid));
      if (eo_valid) chk(out_word == eo_word, {"R6 ", ctx}, "out_word", out_word, eo_word);
      // advance model
      eo_valid = p_valid;
      if (p_valid) eo_word = p_word;
      p_valid = v;
      p_word = w;
      eb_valid = v;
      if (v) begin
         k = w[NW-1:LOW];
         ix = w[LOW-1:WO];
         eb_hit = (mdict[ix] == k);
         if (!eb_hit) begin
            mdict[ix] = k;
            m_key_lines = k;
         end
         eb_word = {m_key_lines, w[LOW-1:0]};
      end
      in_valid = v;
      in_word = w;
   endtask

   function automatic logic [NW-1:0] mk(input logic [KW-1:0] k, input logic [WI-1:0] ix,
                                         input logic [WO-1:0] lo);
      return {k, ix, lo};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [KW-1:0] keys [3];
      for (int e = 0; e < DEPTH; e++) mdict[e] = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!bus_valid && !out_valid, "R1", "valids in reset", NW'({bus_valid, out_valid}), '0);
      chk(bus_word == '0 && out_word == '0, "R1", "words in reset", bus_word | out_word, '0);
      rst_n = 1'b1;
      step(1'b0, '0);
      // R1: still quiet after release
      chk(!bus_valid && bus_word == '0, "R1", "idle after reset", bus_word, '0);

      // R2: zero key hits straight after reset
      ctx = "R2";
      step(1'b1, mk('0, 4'h3, 4'h5));
      step(1'b1, mk('0, 4'h9, 4'hA));
      // R5: miss fills, repeat hits, other key evicts
      ctx = "R5";
      step(1'b1, mk(24'hABCDEF, 4'h2, 4'h1));
      step(1'b0, '0);
      step(1'b1, mk(24'hABCDEF, 4'h2, 4'h7));
      step(1'b1, mk(24'h123456, 4'h2, 4'h0));
      step(1'b1, mk(24'hABCDEF, 4'h2, 4'hF));
      step(1'b1, mk(24'hABCDEF, 4'h2, 4'hE));
      // R8: back-to-back same index, alternating keys then repeat
      ctx = "R8";
      for (int n = 0; n < 8; n++) step(1'b1, mk((n % 2) ? 24'h00FF00 : 24'hF0F0F0, 4'h5, WO'(n)));
      step(1'b1, mk(24'h777777, 4'hC, 4'h1));
      step(1'b1, mk(24'h777777, 4'hC, 4'h2));
      step(1'b1, mk(24'h777777, 4'hC, 4'h3));
      // R7: idle gaps keep lines and tables
      ctx = "R7";
      repeat (4) step(1'b0, 32'hDEADBEEF);
      step(1'b1, mk(24'h777777, 4'hC, 4'h4));

      // random stream with idle cycles
      ctx = "R6 random";
      for (int n = 0; n < 3000; n++) step(($urandom % 5) != 0, $urandom);
      // pattern-heavy stream: few keys, narrow index range
      ctx = "R6 pattern";
      keys[0] = 24'h000000; keys[1] = 24'hFFFFFF; keys[2] = 24'h10A0C0;
      for (int n = 0; n < 3000; n++)
         step(($urandom % 8) != 0,
              mk(keys[$urandom % 3], WI'($urandom % 3), WO'($urandom)));
      repeat (3) step(1'b0, '0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule